// File: doc/BRIEF.md
# PCI IDE Mode Switch Controller

This block holds the configuration-space state of a PCI IDE function whose two channels can each run in legacy mode or native mode. Software selects the mode of each channel through the programming-interface byte of the class-code register. The block takes configuration writes to that byte, to the command register and to the four channel base address registers (BARs). From this state it drives three things: the enable for the fixed legacy I/O port decode of each channel, the enable for native decode of each BAR, and the value read back from the interrupt-pin register.

The mode is evaluated again on every write to the programming-interface byte. The BAR read-back, the decode enables and the interrupt pin all follow on the same clock edge that stores the write, so software never sees a state that mixes the old mode and the new one. While a channel is in legacy mode its BARs read zero and ignore writes. When that channel returns to native mode, its BARs start from an empty address and software must program them again. A reset loads the programming-interface byte, and the interrupt pin is derived from the mode logic alone.

Configuration accesses are addressed by dword index. A write is a single-cycle strobe with byte enables. Read data is a combinational function of the selected dword.

Top module: `ide_mode_switch`

## Requirements
- R1: While reset is asserted and just after it is released, the programming-interface byte is 0x8A, the command register is 0, both channels are legacy, the interrupt pin reads 0, every BAR reads 0 and every decode enable except the legacy ones is 0.
- R2: The programming-interface byte sits in bits 15:8 of dword 2, which reads {0x01, 0x01, byte, 0x00}. A write changes it only when byte enable 1 is set, and then only bits 0 and 2 change; all other bits keep their reset value.
- R3: The primary channel is native exactly when programming-interface bit 0 is 1, and the secondary channel is native exactly when bit 2 is 1. legacy_dec_en[0] and legacy_dec_en[1] are 1 for a legacy channel and 0 for a native one, and they change on the clock edge that stores the write.
- R4: The interrupt pin sits in bits 15:8 of dword 15. It reads 0x01 when at least one channel is native and 0x00 when both are legacy. All other bits of dword 15 read 0.
- R5: The primary channel owns BARs 0 and 1 (dwords 4 and 5), and the secondary channel owns BARs 2 and 3 (dwords 6 and 7). While a channel is legacy, its BARs read 0x00000000, their bar_base slices are 0, their bar_dec_en bits are 0, and writes to them have no effect.
- R6: A BAR of a native channel reads back its stored address with bit 0 = 1 and bit 1 = 0. Address bits below the block size read 0: 8 bytes for the even BARs (bits 2:0) and 4 bytes for the odd BARs (bits 1:0). After its channel has been legacy, a BAR reads 0x00000001 once the channel is native again.
- R7: bar_dec_en[i] is 1 exactly when the channel that owns BAR i is native, command bit 0 (I/O enable) is 1 and the stored address of BAR i is non-zero. bar_base[32*i+31:32*i] gives that address, with bits 1:0 zero, for a native channel.
- R8: Every write changes only the bytes whose byte enable is set. In the command register (dword 1, bits 15:0) only bit 0 is writable; all other bits read 0.
- R9: Dwords other than 1, 2, 4 to 7 and 15 read 0. Writes to them, and to dword 15, change no output and no read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wr_dw | input | 6 | Dword index of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_rd_dw | input | 6 | Dword index of the read |
| cfg_rdata | output | 32 | Read data for cfg_rd_dw, combinational |
| legacy_dec_en | output | 2 | Per channel, enable for the fixed legacy port decode |
| bar_dec_en | output | 4 | Per BAR, enable for native I/O decode |
| bar_base | output | 128 | Per BAR, decoded base address, 32 bits each |
| int_pin | output | 8 | Current interrupt-pin register value |

## Verification
A write is stored on the first rising edge after it is presented. Every result of that write appears right after that edge: the read data for all dwords, both sets of decode enables, the base addresses and the interrupt pin. The one exception is the clearing of a BAR that has fallen into legacy mode, which takes one more edge; it cannot be observed, because a legacy BAR reads zero. The bench therefore presents each write on a falling edge and drops the strobe on the next falling edge. After that falling edge it updates its reference model and compares every output and every readable dword, stepping the read index in small delays within the low phase, so that no sample lands on a rising edge.

// File: rtl/ide_mode_pkg.sv
package ide_mode_pkg;

   // Dword indices inside the function's configuration header
   localparam logic [5:0] DW_CMD   = 6'd1;
   localparam logic [5:0] DW_CLASS = 6'd2;
   localparam logic [5:0] DW_BAR0  = 6'd4;
   localparam logic [5:0] DW_INTR  = 6'd15;

   localparam int unsigned NUM_CH     = 2;
   localparam int unsigned BARS_PER_CH = 2;

   // Programming-interface bit that selects native mode for a channel
   function automatic int unsigned mode_bit(input int unsigned ch);
      return 2 * ch;
   endfunction

   // Merge the enabled bytes of a new word into an old one
   function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  be);
      logic [31:0] res;
      for (int b = 0; b < 4; b++) begin
         res[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/ide_mode_regs.sv
module ide_mode_regs
   import ide_mode_pkg::*;
#(
   parameter logic [7:0]  PROGIF_RST   = 8'h8A,
   parameter logic [7:0]  PROGIF_WMASK = 8'h05,
   parameter logic [15:0] CMD_WMASK    = 16'h0001
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [5:0]        wr_dw,
   input  logic [15:0]       wdata,
   input  logic [1:0]        be,
   output logic [7:0]        progif_q,
   output logic [15:0]       cmd_q,
   output logic [NUM_CH-1:0] chan_native,
   output logic              io_en
);

   if (2 * NUM_CH > 8) begin : g_bad_ch
      $error("channel mode bits do not fit in the programming-interface byte");
   end
   if (CMD_WMASK[0] == 1'b0) begin : g_bad_cmd
      $error("command I/O enable bit must be writable");
   end

   logic        class_wr;
   logic        cmd_wr;
   logic [15:0] cmd_merged;

   assign class_wr = wr_en && (wr_dw == DW_CLASS) && be[1];
   assign cmd_wr   = wr_en && (wr_dw == DW_CMD);

   always_comb begin
      for (int b = 0; b < 2; b++) begin
         cmd_merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : cmd_q[8*b +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         progif_q <= PROGIF_RST;
         cmd_q    <= '0;
      end else begin
         if (class_wr) begin
            progif_q <= (progif_q & ~PROGIF_WMASK) | (wdata[15:8] & PROGIF_WMASK);
         end
         if (cmd_wr) begin
            cmd_q <= cmd_merged & CMD_WMASK;
         end
      end
   end

   assign io_en = cmd_q[0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      localparam int unsigned MB = mode_bit(ch);
      assign chan_native[ch] = progif_q[MB];

      if (PROGIF_WMASK[MB]) begin : g_wr_chk
         // R3
         mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            class_wr |=> (chan_native[ch] == $past(wdata[8 + MB])));
      end
   end

   // R2
   ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((progif_q & ~PROGIF_WMASK) == (PROGIF_RST & ~PROGIF_WMASK)));

   // R2
   no_be_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!class_wr) |=> $stable(progif_q));

endmodule

// File: rtl/ide_bar_reg.sv
module ide_bar_reg
   import ide_mode_pkg::*;
#(
   parameter int unsigned BLK_BYTES = 8
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        native,
   input  logic        io_en,
   input  logic        wr_sel,
   input  logic [31:0] wdata,
   input  logic [3:0]  be,
   output logic [31:0] rd_val,
   output logic [31:0] base_o,
   output logic        dec_en
);

   localparam int unsigned LOW_BITS = $clog2(BLK_BYTES);
   localparam logic [31:0] ADDR_MASK = ~((32'd1 << LOW_BITS) - 32'd1);

   if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("I/O block size must be a power of two of at least 4 bytes");
   end

   logic [31:0] addr_q;

   // A legacy channel keeps its BARs empty, so a later switch to native starts clean
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (!native) begin
         addr_q <= '0;
      end else if (wr_sel) begin
         addr_q <= be_merge(addr_q, wdata, be) & ADDR_MASK;
      end
   end

   assign rd_val = native ? (addr_q | 32'h0000_0001) : 32'h0;
   assign base_o = native ? addr_q : 32'h0;
   assign dec_en = native && io_en && (addr_q != '0);

   // R5
   legacy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!native) |=> (base_o == '0));

   // R6
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && native && be == 4'hF) |=>
         (!native || base_o == ($past(wdata) & ADDR_MASK)));

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
   import ide_mode_pkg::*;
#(
   parameter int unsigned NUM_BARS   = 4,
   parameter logic [7:0]  CLASS_BASE = 8'h01,
   parameter logic [7:0]  SUB_CLASS  = 8'h01,
   parameter logic [7:0]  REV_ID     = 8'h00
)(
   input  logic [5:0]             rd_dw,
   input  logic [7:0]             progif,
   input  logic [15:0]            cmd,
   input  logic [32*NUM_BARS-1:0] bar_rd,
   input  logic [7:0]             int_pin,
   output logic [31:0]            rdata
);

   always_comb begin
      rdata = 32'h0;
      if (rd_dw == DW_CMD) begin
         rdata = {16'h0, cmd};
      end else if (rd_dw == DW_CLASS) begin
         rdata = {CLASS_BASE, SUB_CLASS, progif, REV_ID};
      end else if (rd_dw == DW_INTR) begin
         rdata = {16'h0, int_pin, 8'h00};
      end else begin
         for (int i = 0; i < NUM_BARS; i++) begin
            if (rd_dw == DW_BAR0 + 6'(i)) begin
               rdata = bar_rd[32*i +: 32];
            end
         end
      end
   end

endmodule

// File: rtl/ide_mode_switch.sv
module ide_mode_switch
   import ide_mode_pkg::*;
#(
   parameter logic [7:0]  PROGIF_RST    = 8'h8A,
   parameter logic [7:0]  PROGIF_WMASK  = 8'h05,
   parameter logic [15:0] CMD_WMASK     = 16'h0001,
   parameter logic [7:0]  INT_PIN_VAL   = 8'h01,
   parameter int unsigned CMD_BLK_BYTES = 8,
   parameter int unsigned CTL_BLK_BYTES = 4,
   parameter logic [7:0]  CLASS_BASE    = 8'h01,
   parameter logic [7:0]  SUB_CLASS     = 8'h01,
   parameter logic [7:0]  REV_ID        = 8'h00
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_wr_en,
   input  logic [5:0]   cfg_wr_dw,
   input  logic [31:0]  cfg_wdata,
   input  logic [3:0]   cfg_be,
   input  logic [5:0]   cfg_rd_dw,
   output logic [31:0]  cfg_rdata,
   output logic [1:0]   legacy_dec_en,
   output logic [3:0]   bar_dec_en,
   output logic [127:0] bar_base,
   output logic [7:0]   int_pin
);

   localparam int unsigned NUM_BARS = NUM_CH * BARS_PER_CH;

   if (INT_PIN_VAL < 8'd1 || INT_PIN_VAL > 8'd4) begin : g_bad_pin
      $error("native interrupt pin must name one of the four PCI pins");
   end

   logic [7:0]             progif_q;
   logic [15:0]            cmd_q;
   logic [NUM_CH-1:0]      chan_native;
   logic                   io_en;
   logic [32*NUM_BARS-1:0] bar_rd;

   ide_mode_regs #(
      .PROGIF_RST  (PROGIF_RST),
      .PROGIF_WMASK(PROGIF_WMASK),
      .CMD_WMASK   (CMD_WMASK)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_dw      (cfg_wr_dw),
      .wdata      (cfg_wdata[15:0]),
      .be         (cfg_be[1:0]),
      .progif_q   (progif_q),
      .cmd_q      (cmd_q),
      .chan_native(chan_native),
      .io_en      (io_en)
   );

   for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      localparam int unsigned CH  = b / BARS_PER_CH;
      localparam int unsigned BLK = (b % BARS_PER_CH == 0) ? CMD_BLK_BYTES : CTL_BLK_BYTES;
      logic wr_sel;
      assign wr_sel = cfg_wr_en && (cfg_wr_dw == DW_BAR0 + 6'(b));

      ide_bar_reg #(.BLK_BYTES(BLK)) u_bar (
         .clk   (clk),
         .rst_n (rst_n),
         .native(chan_native[CH]),
         .io_en (io_en),
         .wr_sel(wr_sel),
         .wdata (cfg_wdata),
         .be    (cfg_be),
         .rd_val(bar_rd[32*b +: 32]),
         .base_o(bar_base[32*b +: 32]),
         .dec_en(bar_dec_en[b])
      );

      // R7
      excl_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bar_dec_en[b] |-> !legacy_dec_en[CH]);

      // R7
      dec_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bar_dec_en[b] |-> cmd_q[0]);
   end

   assign legacy_dec_en = ~chan_native;
   assign int_pin       = (|chan_native) ? INT_PIN_VAL : 8'h00;

   ide_cfg_rdmux #(
      .NUM_BARS  (NUM_BARS),
      .CLASS_BASE(CLASS_BASE),
      .SUB_CLASS (SUB_CLASS),
      .REV_ID    (REV_ID)
   ) u_rdmux (
      .rd_dw  (cfg_rd_dw),
      .progif (progif_q),
      .cmd    (cmd_q),
      .bar_rd (bar_rd),
      .int_pin(int_pin),
      .rdata  (cfg_rdata)
   );

   // R4
   pin_vs_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((int_pin != 8'h00) == (legacy_dec_en != 2'b11)));

endmodule

// File: tb/ide_mode_switch_tb.sv
`timescale 1ns/1ps
module ide_mode_switch_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_wr_en;
   logic [5:0]   cfg_wr_dw;
   logic [31:0]  cfg_wdata;
   logic [3:0]   cfg_be;
   logic [5:0]   cfg_rd_dw;
   logic [31:0]  cfg_rdata;
   logic [1:0]   legacy_dec_en;
   logic [3:0]   bar_dec_en;
   logic [127:0] bar_base;
   logic [7:0]   int_pin;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;
   bit          done   = 0;

   always #2.5 clk = ~clk;

   ide_mode_switch dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
      .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rd_dw(cfg_rd_dw),
      .cfg_rdata(cfg_rdata), .legacy_dec_en(legacy_dec_en),
      .bar_dec_en(bar_dec_en), .bar_base(bar_base), .int_pin(int_pin)
   );

   // Reference model of the configuration state
   logic [7:0]  m_prog;
   logic        m_io;
   logic [31:0] m_bar [4];

   function automatic bit nat(input int ch);
      return m_prog[2*ch];
   endfunction

   function automatic logic [31:0] bar_mask(input int i);
      return (i % 2 == 0) ? 32'hFFFF_FFF8 : 32'hFFFF_FFFC;
   endfunction

   function automatic logic [7:0] exp_pin();
      return (nat(0) || nat(1)) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [5:0] dw);
      case (dw)
         6'd1:  return {31'h0, m_io};
         6'd2:  return {8'h01, 8'h01, m_prog, 8'h00};
         6'd4, 6'd5, 6'd6, 6'd7:
                return nat((dw - 4) / 2) ? (m_bar[dw - 4] | 32'h1) : 32'h0;
         6'd15: return {16'h0, exp_pin(), 8'h00};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [5:0] dw);
      case (dw)
         6'd1:  return "R8";
         6'd2:  return "R2";
         6'd4, 6'd5, 6'd6, 6'd7: return nat((dw - 4) / 2) ? "R6" : "R5";
         6'd15: return "R4";
         default: return "R9";
      endcase
   endfunction

   task automatic model_reset();
      m_prog = 8'h8A;
      m_io   = 1'b0;
      for (int i = 0; i < 4; i++) m_bar[i] = 32'h0;
   endtask

   task automatic model_write(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be);
      if (dw == 6'd1 && be[0]) m_io = d[0];
      if (dw == 6'd2 && be[1]) m_prog = (m_prog & ~8'h05) | (d[15:8] & 8'h05);
      if (dw >= 6'd4 && dw <= 6'd7) begin
         int i = dw - 4;
         if (nat(i / 2)) begin
            for (int b = 0; b < 4; b++) if (be[b]) m_bar[i][8*b +: 8] = d[8*b +: 8];
            m_bar[i] = m_bar[i] & bar_mask(i);
         end
      end
      for (int i = 0; i < 4; i++) if (!nat(i / 2)) m_bar[i] = 32'h0;
   endtask

   task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Called in the low phase of the clock; all results are combinational from state
   task automatic check_all(input string force_tag);
      logic [5:0] dws [10] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd15};
      logic [3:0]   e_dec;
      logic [127:0] e_base;
      for (int k = 0; k < 10; k++) begin
         cfg_rd_dw = dws[k];
         #0.1;
         chk(force_tag != "" ? force_tag : rd_tag(dws[k]), $sformatf("rdata dw%0d", dws[k]),
             {96'h0, cfg_rdata}, {96'h0, exp_rd(dws[k])});
      end
      for (int i = 0; i < 4; i++) begin
         e_dec[i] = nat(i / 2) && m_io && (m_bar[i] != 0);
         e_base[32*i +: 32] = nat(i / 2) ? m_bar[i] : 32'h0;
      end
      chk(force_tag != "" ? force_tag : "R3", "legacy_dec_en", {126'h0, legacy_dec_en},
          {126'h0, !nat(1), !nat(0)});
      chk(force_tag != "" ? force_tag : "R7", "bar_dec_en", {124'h0, bar_dec_en}, {124'h0, e_dec});
      chk(force_tag != "" ? force_tag : "R7", "bar_base", bar_base, e_base);
      chk(force_tag != "" ? force_tag : "R4", "int_pin", {120'h0, int_pin}, {120'h0, exp_pin()});
   endtask

   task automatic cfg_write(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be, input string tag);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wr_dw = dw;
      cfg_wdata = d;
      cfg_be    = be;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      model_write(dw, d, be);
      check_all(tag);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      logic [5:0] pool [10] = '{6'd0, 6'd1, 6'd2, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd15};
      void'($urandom(32'h5EED_1DE5));
      rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_dw = '0; cfg_wdata = '0; cfg_be = '0; cfg_rd_dw = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R1");              // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");              // R1 after release

      // R2 R3 R4: both channels native; only bits 0 and 2 may change
      cfg_write(6'd2, 32'h0000_FF00, 4'hF, "");
      // R6: full-ones address, low bits forced by block size
      cfg_write(6'd4, 32'hFFFF_FFFF, 4'hF, "R6");
      cfg_write(6'd5, 32'hFFFF_FFFF, 4'hF, "R6");
      // R7: decode waits for the I/O enable
      cfg_write(6'd1, 32'hFFFF_FFFF, 4'hF, "R7");
      // R8: only byte 0 of BAR0 changes
      cfg_write(6'd4, 32'h1234_5670, 4'b0001, "R8");
      // R2: without byte enable 1 the mode byte stays
      cfg_write(6'd2, 32'h0000_0000, 4'b1101, "R2");
      // R3 R5: primary back to legacy, secondary native
      cfg_write(6'd2, 32'h0000_0400, 4'b0010, "");
      // R5: write to a legacy BAR is ignored
      cfg_write(6'd4, 32'h0000_1230, 4'hF, "R5");
      // R6: primary native again, BAR starts empty
      cfg_write(6'd2, 32'h0000_0500, 4'hF, "R6");
      // R9: unused and read-only dwords
      cfg_write(6'd0, 32'hFFFF_FFFF, 4'hF, "R9");
      cfg_write(6'd3, 32'hFFFF_FFFF, 4'hF, "R9");
      cfg_write(6'd15, 32'hFFFF_FFFF, 4'hF, "R9");
      // R4: both legacy gives pin zero
      cfg_write(6'd2, 32'h0000_0000, 4'hF, "R4");

      // Constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic [5:0]  dw;
         logic [31:0] d;
         logic [3:0]  be;
         dw = pool[$urandom_range(0, 9)];
         d  = $urandom();
         be = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) == 0) d[31:8] = '0;
         cfg_write(dw, d, be, "");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule